// File: doc/BRIEF.md
# Endpoint Receive Byte Tally

This block keeps the receive-side tally for one endpoint. While an OUT packet is in progress it counts the data strobes the USB core issues, one per byte. When the core closes the packet with an acknowledge or a negative acknowledge, the counter stops. The final count is then captured into a 16-bit status word that the CPU can read. The word also carries a packet-valid flag, a saturation flag and an occupied flag.

The block also decides whether the endpoint can take another packet. It is ready only when three things hold: the receive FIFO reports empty, the status word has been cleared by a CPU read, and no packet is in progress. A packet start while the endpoint is not ready is refused, and the core answers the host with a negative acknowledge. A separate receive-done interrupt pulses once the transfer engine reports that the captured packet has fully left the FIFO. A CPU read clears the status word and re-enables the transfer engine's word-transfer request.

Top module: `rx_tally`

## Requirements
- R1: While a packet is in progress, each cycle with `strobe_i` high adds one to the running count. The count restarts from zero when a packet is accepted. Strobes outside a packet, and a strobe in the cycle that ends a packet, are not counted.
- R2: When `end_ack_i` is high during a packet, the next cycle shows the status word with the count in bits 9:0, bit 15 (valid) = 1 and bit 13 (occupied) = 1. Acknowledge wins if both end inputs are high.
- R3: When `end_nak_i` alone is high during a packet, the same capture takes place with bit 15 = 0.
- R4: The count saturates at 1023 and does not wrap. A strobe counted at 1023 sets bit 14 (saturated) in the captured word.
- R5: `irq_o` pulses for one cycle, one cycle after `drain_done_i`, but only for a captured packet not yet signalled. Any other `drain_done_i` has no effect.
- R6: `rdy_o` is high exactly when `fifo_empty_i` is high, bit 13 of the status word is 0, and no packet is in progress.
- R7: A `pkt_start_i` while `rdy_o` is low gives a one-cycle `refuse_o` pulse in the next cycle. The status word and the running count are left unchanged.
- R8: `rd_data_o` always shows the status word. A cycle with `cpu_rd_i` high clears the word to zero from the next cycle on, unless a capture happens in that same cycle.
- R9: After reset the status word is 0, `irq_o` and `refuse_o` are 0, and `xfer_en_o` is 1.
- R10: `xfer_en_o` falls in the cycle after the drain of a captured packet and rises again in the cycle after a CPU read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_start_i | input | 1 | Core asks to begin an OUT packet (handshake request) |
| strobe_i | input | 1 | One data byte written by the core |
| end_ack_i | input | 1 | Packet ended with acknowledge |
| end_nak_i | input | 1 | Packet ended with negative acknowledge |
| fifo_empty_i | input | 1 | Receive FIFO is empty |
| drain_done_i | input | 1 | Transfer engine has moved the whole packet out |
| cpu_rd_i | input | 1 | CPU read strobe for the status word |
| rd_data_o | output | 16 | Status word: count[9:0], occupied[13], saturated[14], valid[15] |
| rdy_o | output | 1 | Endpoint can accept a packet |
| refuse_o | output | 1 | Pulse: a start request was refused |
| irq_o | output | 1 | Receive-done interrupt pulse |
| xfer_en_o | output | 1 | Word-transfer request enable toward the transfer engine |

## Verification
Most results are due one cycle after their cause: the captured word after an end cycle, the cleared word after a read, the interrupt after a drain, the refusal after a rejected start, and the change of `xfer_en_o`. Only `rdy_o` and `rd_data_o` follow registered state and inputs within the same cycle. The bench drives inputs just after a rising edge and samples on the falling edge of the cycle where each result is due. The scoreboard queues the expected status word before each CPU read and compares it in the falling-edge half of the read cycle.

// File: rtl/rx_tally_pkg.sv
package rx_tally_pkg;
    localparam int CNT_W   = 10;
    localparam int WORD_W  = 16;
    localparam int VALID_B = 15;
    localparam int SAT_B   = 14;
    localparam int OCC_B   = 13;

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
        logic             sat;
    } tally_st_t;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              pend;
        logic              irq;
        logic              xfer_en;
    } stat_st_t;

    typedef struct packed {
        logic refuse;
    } gate_st_t;
endpackage

// File: rtl/rx_tally_count.sv
module rx_tally_count
    import rx_tally_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         accept_i,
    input  logic         strobe_i,
    input  logic         end_any_i,
    output logic         active_o,
    output logic [W-1:0] cnt_o,
    output logic         sat_o
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    logic         act_d, act_q, sat_d, sat_q;
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        act_d = act_q;
        cnt_d = cnt_q;
        sat_d = sat_q;
        if (accept_i) begin
            act_d = 1'b1;
            cnt_d = '0;
            sat_d = 1'b0;
        end else if (act_q && end_any_i) begin
            act_d = 1'b0;
        end else if (act_q && strobe_i) begin
            if (cnt_q == TOP) sat_d = 1'b1;
            else              cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
            cnt_q <= '0;
            sat_q <= 1'b0;
        end else begin
            act_q <= act_d;
            cnt_q <= cnt_d;
            sat_q <= sat_d;
        end
    end

    assign active_o = act_q;
    assign cnt_o    = cnt_q;
    assign sat_o    = sat_q;
endmodule

// File: rtl/rx_tally_stat.sv
module rx_tally_stat
    import rx_tally_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic              valid_i,
    input  logic              sat_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              drain_done_i,
    input  logic              cpu_rd_i,
    output logic [WORD_W-1:0] word_o,
    output logic              irq_o,
    output logic              xfer_en_o
);
    stat_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (capture_i) begin
            st_d.word              = '0;
            st_d.word[CNT_W-1:0]   = cnt_i;
            st_d.word[VALID_B]     = valid_i;
            st_d.word[SAT_B]       = sat_i;
            st_d.word[OCC_B]       = 1'b1;
            st_d.pend              = 1'b1;
        end else if (cpu_rd_i) begin
            st_d.word = '0;
        end
        if (drain_done_i && st_q.pend) begin
            st_d.irq     = 1'b1;
            st_d.pend    = capture_i;
            st_d.xfer_en = 1'b0;
        end
        if (cpu_rd_i) st_d.xfer_en = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.word    <= '0;
            st_q.pend    <= 1'b0;
            st_q.irq     <= 1'b0;
            st_q.xfer_en <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o    = st_q.word;
    assign irq_o     = st_q.irq;
    assign xfer_en_o = st_q.xfer_en;
endmodule

// File: rtl/rx_tally_gate.sv
module rx_tally_gate
    import rx_tally_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pkt_start_i,
    input  logic fifo_empty_i,
    input  logic occupied_i,
    input  logic active_i,
    output logic rdy_o,
    output logic accept_o,
    output logic refuse_o
);
    gate_st_t st_d, st_q;
    logic     rdy;

    always_comb begin
        rdy          = fifo_empty_i && !occupied_i && !active_i;
        st_d.refuse  = pkt_start_i && !rdy;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.refuse <= 1'b0;
        else        st_q        <= st_d;
    end

    assign rdy_o    = rdy;
    assign accept_o = pkt_start_i && rdy;
    assign refuse_o = st_q.refuse;
endmodule

// File: rtl/rx_tally.sv
module rx_tally
    import rx_tally_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pkt_start_i,
    input  logic              strobe_i,
    input  logic              end_ack_i,
    input  logic              end_nak_i,
    input  logic              fifo_empty_i,
    input  logic              drain_done_i,
    input  logic              cpu_rd_i,
    output logic [WORD_W-1:0] rd_data_o,
    output logic              rdy_o,
    output logic              refuse_o,
    output logic              irq_o,
    output logic              xfer_en_o
);
    logic             accept, active, sat, end_any, capture;
    logic [CNT_W-1:0] cnt;
    logic [WORD_W-1:0] word;

    assign end_any = end_ack_i || end_nak_i;
    assign capture = active && end_any;

    rx_tally_gate i_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .pkt_start_i  (pkt_start_i),
        .fifo_empty_i (fifo_empty_i),
        .occupied_i   (word[OCC_B]),
        .active_i     (active),
        .rdy_o        (rdy_o),
        .accept_o     (accept),
        .refuse_o     (refuse_o)
    );

    rx_tally_count #(.W(CNT_W)) i_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_i  (accept),
        .strobe_i  (strobe_i),
        .end_any_i (end_any),
        .active_o  (active),
        .cnt_o     (cnt),
        .sat_o     (sat)
    );

    rx_tally_stat i_stat (
        .clk          (clk),
        .rst_n        (rst_n),
        .capture_i    (capture),
        .valid_i      (end_ack_i),
        .sat_i        (sat),
        .cnt_i        (cnt),
        .drain_done_i (drain_done_i),
        .cpu_rd_i     (cpu_rd_i),
        .word_o       (word),
        .irq_o        (irq_o),
        .xfer_en_o    (xfer_en_o)
    );

    assign rd_data_o = word;
endmodule

// File: rtl/rx_tally_chk.sv
module rx_tally_chk
    import rx_tally_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              pkt_start_i,
    input logic              end_ack_i,
    input logic              end_nak_i,
    input logic              fifo_empty_i,
    input logic              drain_done_i,
    input logic              cpu_rd_i,
    input logic [WORD_W-1:0] rd_data_o,
    input logic              rdy_o,
    input logic              refuse_o,
    input logic              irq_o
);
    assert_irq_after_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(drain_done_i));

    assert_refuse_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        refuse_o |-> $past(pkt_start_i && !rdy_o));

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd_i && !end_ack_i && !end_nak_i) |=> (rd_data_o == '0));

    assert_ready_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_o |-> (fifo_empty_i && !rd_data_o[OCC_B]));

    assert_sat_pinned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[SAT_B] |-> (rd_data_o[CNT_W-1:0] == {CNT_W{1'b1}}));

    assert_valid_from_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data_o[VALID_B]) |-> $past(end_ack_i));
endmodule

bind rx_tally rx_tally_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pkt_start_i  (pkt_start_i),
    .end_ack_i    (end_ack_i),
    .end_nak_i    (end_nak_i),
    .fifo_empty_i (fifo_empty_i),
    .drain_done_i (drain_done_i),
    .cpu_rd_i     (cpu_rd_i),
    .rd_data_o    (rd_data_o),
    .rdy_o        (rdy_o),
    .refuse_o     (refuse_o),
    .irq_o        (irq_o)
);

// File: tb/test_rx_tally.sv
module test_rx_tally;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pkt_start_i = 0, strobe_i = 0, end_ack_i = 0, end_nak_i = 0;
    logic        fifo_empty_i = 1, drain_done_i = 0, cpu_rd_i = 0;
    logic [15:0] rd_data_o;
    logic        rdy_o, refuse_o, irq_o, xfer_en_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    rx_tally i_rx_tally (
        .clk(clk), .rst_n(rst_n), .pkt_start_i(pkt_start_i), .strobe_i(strobe_i),
        .end_ack_i(end_ack_i), .end_nak_i(end_nak_i), .fifo_empty_i(fifo_empty_i),
        .drain_done_i(drain_done_i), .cpu_rd_i(cpu_rd_i), .rd_data_o(rd_data_o),
        .rdy_o(rdy_o), .refuse_o(refuse_o), .irq_o(irq_o), .xfer_en_o(xfer_en_o)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: compares each CPU read against the queued expectation
    always @(negedge clk) begin
        if (rst_n && cpu_rd_i) begin
            if (exp_q.size() == 0) begin
                check("R8 unexpected read", rd_data_o, 16'hxxxx);
            end else begin
                check(tag_q.pop_front(), rd_data_o, exp_q.pop_front());
            end
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic send(input int n, input bit ack, input bit nak);
        step(); pkt_start_i = 1;
        step(); pkt_start_i = 0;
        for (int i = 0; i < n; i++) begin strobe_i = 1; step(); end
        strobe_i = 1; end_ack_i = ack; end_nak_i = nak;  // strobe in end cycle not counted
        step(); strobe_i = 0; end_ack_i = 0; end_nak_i = 0;
    endtask

    task automatic drain();
        drain_done_i = 1; step(); drain_done_i = 0;
    endtask

    task automatic cpu_read(input string tag, input logic [15:0] exp);
        exp_q.push_back(exp); tag_q.push_back(tag);
        cpu_rd_i = 1; step(); cpu_rd_i = 0;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check("R9 word", rd_data_o, 16'h0000);
        check("R9 xfer_en", {15'b0, xfer_en_o}, 16'h1);
        check("R9 irq/refuse", {14'b0, irq_o, refuse_o}, 16'h0);
        check("R6 ready idle", {15'b0, rdy_o}, 16'h1);

        // R2 acknowledged packet of 5
        send(5, 1, 0);
        @(negedge clk);
        check("R2 captured", rd_data_o, 16'hA005);
        check("R6 busy", {15'b0, rdy_o}, 16'h0);
        step(); drain_done_i = 1;
        step(); drain_done_i = 0;
        @(negedge clk);
        check("R5 irq", {15'b0, irq_o}, 16'h1);
        check("R10 xfer off", {15'b0, xfer_en_o}, 16'h0);
        step(); cpu_read("R8 read ack", 16'hA005);
        @(negedge clk);
        check("R8 cleared", rd_data_o, 16'h0000);
        check("R10 xfer on", {15'b0, xfer_en_o}, 16'h1);
        check("R5 irq one pulse", {15'b0, irq_o}, 16'h0);

        // R3 negative acknowledge
        send(3, 0, 1);
        drain();
        cpu_read("R3 nak word", 16'h2003);

        // R1 strobes outside packet ignored
        strobe_i = 1; repeat (4) step(); strobe_i = 0;
        send(2, 1, 1);
        cpu_read("R1 count 2 ack wins", 16'hA002);
        drain();

        // R5 drain with nothing pending
        step(); drain_done_i = 1; step(); drain_done_i = 0;
        @(negedge clk);
        check("R5 no irq", {15'b0, irq_o}, 16'h0);

        // R6/R7 fifo not empty
        fifo_empty_i = 0; step();
        @(negedge clk);
        check("R6 fifo busy", {15'b0, rdy_o}, 16'h0);
        step(); pkt_start_i = 1; strobe_i = 1;
        step(); pkt_start_i = 0; end_ack_i = 1;
        @(negedge clk);
        check("R7 refuse", {15'b0, refuse_o}, 16'h1);
        step(); strobe_i = 0; end_ack_i = 0;
        @(negedge clk);
        check("R7 word untouched", rd_data_o, 16'h0000);
        fifo_empty_i = 1;

        // R7 refusal while word unread
        send(1, 0, 1);
        step(); pkt_start_i = 1;
        step(); pkt_start_i = 0;
        @(negedge clk);
        check("R7 refuse unread", {15'b0, refuse_o}, 16'h1);
        cpu_read("R7 word kept", 16'h2001);

        // R4 saturation
        send(1030, 1, 0);
        drain();
        cpu_read("R4 saturated", 16'hE3FF);

        // R1 empty packet
        send(0, 0, 1);
        cpu_read("R1 zero count", 16'h2000);

        repeat (3) step();
        check("R8 queue drained", 16'(exp_q.size()), 16'h0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule